// File: doc/BRIEF.md
# Block Carry-Lookahead Adder

This block is a purely combinational N-bit adder. It takes two N-bit operands and a carry-in, and it returns the N-bit sum and the carry-out. The columns are grouped into K-bit blocks.

Each block reduces its column generate and propagate terms to one block generate and one block propagate. These two terms fix the block's carry-out as soon as the block's carry-in is known. The carry therefore passes from block to block through a single AND-OR stage per block. Inside each block the sum bits still ripple from column to column.

The block suits datapaths that need a faster carry chain than a plain ripple adder and can spend a modest amount of extra logic on it. With the default settings it is 32 bits wide, built from eight 4-bit blocks.

Top module: `cla_adder`

## Requirements
- R1: `sum_out` equals the low N bits of `a_in + b_in + c_in`, with all values taken as unsigned.
- R2: `c_out` equals bit N of the (N+1)-bit unsigned sum `a_in + b_in + c_in`.
- R3: The lookahead carry out of every block, formed as block generate OR (block propagate AND the block's carry-in), equals the carry that ripples out of that block's top column.
- R4: When every column propagates but none generates (`b_in == ~a_in`), `c_in` passes through all blocks. So `c_out == c_in`, and `sum_out` is all ones when `c_in` is 0 and all zeros when `c_in` is 1.
- R5: All-ones plus one wraps around: `a_in` all ones, `b_in` zero and `c_in` 1 give `sum_out` zero and `c_out` 1. The same result comes from `a_in` all ones, `b_in` equal to 1 and `c_in` 0.
- R6: When every column generates (both operands all ones), `c_out` is 1 whatever `c_in` is. `sum_out` is all ones when `c_in` is 1 and all ones except bit 0 when `c_in` is 0.
- R7: All-zero operands with a zero carry-in give a zero sum and a zero carry-out.
- R8: N must be a whole multiple of K. Any other pair of values is rejected when the design is elaborated.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_in | input | N | First operand |
| b_in | input | N | Second operand |
| c_in | input | 1 | Carry into the lowest block |
| sum_out | output | N | Sum, modulo 2^N |
| c_out | output | 1 | Carry out of the top block |

## Verification
The immediate checks inside the adder assume that the operands and the carry-in are known 0/1 values that have settled before they are compared. There is no clock in the block, so a check made while inputs are still changing has no meaning. The bench changes the inputs only just after a rising clock edge and reads the outputs 2 ns later, once the combinational logic has settled. It never drives unknown values.

// File: rtl/cla_adder.sv
module cla_adder #(
  parameter int N = 32,
  parameter int K = 4
) (
  input  logic [N-1:0] a_in,
  input  logic [N-1:0] b_in,
  input  logic         c_in,
  output logic [N-1:0] sum_out,
  output logic         c_out
);
  localparam int NB = N / K;

  if ((N % K) != 0 || K < 1) begin : g_bad_cfg
    $error("cla_adder: N must be a whole multiple of K"); // R8
  end

  logic [N-1:0]  gen;
  logic [N-1:0]  prop;
  logic [N-1:0]  col_ci;
  logic [N-1:0]  col_co;
  logic [NB:0]   blk_c;
  logic [NB-1:0] blk_g;
  logic [NB-1:0] blk_p;

  assign gen   = a_in & b_in;
  assign prop  = a_in | b_in;
  assign blk_c[0] = c_in;
  assign c_out = blk_c[NB];

  for (genvar bi = 0; bi < NB; bi++) begin : g_blk
    logic [K-1:0] g_acc;
    logic [K-1:0] p_acc;

    for (genvar ci = 0; ci < K; ci++) begin : g_col
      localparam int IX = bi * K + ci;
      if (ci == 0) begin : g_first
        assign g_acc[ci]  = gen[IX];
        assign p_acc[ci]  = prop[IX];
        assign col_ci[IX] = blk_c[bi];
      end else begin : g_next
        assign g_acc[ci]  = gen[IX] | (prop[IX] & g_acc[ci-1]);
        assign p_acc[ci]  = prop[IX] & p_acc[ci-1];
        assign col_ci[IX] = col_co[IX-1];
      end
      assign col_co[IX]  = gen[IX] | (prop[IX] & col_ci[IX]);
      assign sum_out[IX] = a_in[IX] ^ b_in[IX] ^ col_ci[IX];
    end

    assign blk_g[bi]   = g_acc[K-1];
    assign blk_p[bi]   = p_acc[K-1];
    assign blk_c[bi+1] = blk_g[bi] | (blk_p[bi] & blk_c[bi]);
  end

  always_comb begin
    AST_SUM_MATCH: assert ({c_out, sum_out} == ({1'b0, a_in} + {1'b0, b_in} + {{N{1'b0}}, c_in})); // R1
    for (int bi = 0; bi < NB; bi++) begin
      AST_BLOCK_CARRY: assert (blk_c[bi+1] == col_co[bi*K + K - 1]); // R3
    end
    if (((a_in ^ b_in) == {N{1'b1}})) begin
      AST_ALL_PROPAGATE: assert (c_out == c_in); // R4
    end
    if ((a_in & b_in) == {N{1'b1}}) begin
      AST_ALL_GENERATE: assert (c_out); // R6
    end
  end
endmodule

// File: tb/cla_adder_tb.sv
module cla_adder_tb;
  localparam int N = 32;
  localparam int K = 4;
  localparam int NV = 8;
  localparam logic [64:0] TBL [NV] = '{
    {32'h0000_0001, 32'h0000_0001, 1'b0},
    {32'h0000_000F, 32'h0000_0001, 1'b0},
    {32'h0000_FFFF, 32'h0000_0001, 1'b0},
    {32'h1234_5678, 32'h8765_4321, 1'b1},
    {32'h8000_0000, 32'h8000_0000, 1'b0},
    {32'h7FFF_FFFF, 32'h0000_0001, 1'b0},
    {32'hF0F0_F0F0, 32'h0F0F_0F10, 1'b0},
    {32'hDEAD_BEEF, 32'h2152_4110, 1'b1}
  };

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic [N-1:0] a, b, s;
  logic ci, co;
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  cla_adder #(.N(N), .K(K)) u_dut (
    .a_in(a), .b_in(b), .c_in(ci), .sum_out(s), .c_out(co)
  );

  task automatic apply(input string req, input logic [N-1:0] ta, input logic [N-1:0] tb_v,
                       input logic tc);
    logic [N:0] exp_v;
    @(posedge clk);
    #1;
    a = ta; b = tb_v; ci = tc;
    #2;
    exp_v = {1'b0, ta} + {1'b0, tb_v} + {{N{1'b0}}, tc};
    checks++;
    if ({co, s} !== exp_v) begin
      fails++;
      $display("FAIL %s a=%h b=%h cin=%0b actual={%0b,%h} expected={%0b,%h}",
               req, ta, tb_v, tc, co, s, exp_v[N], exp_v[N-1:0]);
    end
  endtask

  task automatic expect_val(input string req, input logic [N-1:0] es, input logic ec);
    checks++;
    if (s !== es || co !== ec) begin
      fails++;
      $display("FAIL %s actual={%0b,%h} expected={%0b,%h}", req, co, s, ec, es);
    end
  endtask

  initial begin
    a = '0; b = '0; ci = 1'b0;
    apply("R7 zero inputs", '0, '0, 1'b0);
    expect_val("R7 zero result", '0, 1'b0);

    for (int i = 0; i < NV; i++)
      apply("R1 R2 table", TBL[i][64:33], TBL[i][32:1], TBL[i][0]);

    apply("R5 ones plus cin", {N{1'b1}}, '0, 1'b1);
    expect_val("R5 wrap", '0, 1'b1);
    apply("R5 ones plus one", {N{1'b1}}, {{(N-1){1'b0}}, 1'b1}, 1'b0);
    expect_val("R5 wrap b", '0, 1'b1);

    apply("R4 propagate cin0", 32'hA5A5_5A5A, 32'h5A5A_A5A5, 1'b0);
    expect_val("R4 pass 0", {N{1'b1}}, 1'b0);
    apply("R4 propagate cin1", 32'hA5A5_5A5A, 32'h5A5A_A5A5, 1'b1);
    expect_val("R4 pass 1", '0, 1'b1);
    apply("R4 R3 ones vs zero", '0, {N{1'b1}}, 1'b1);
    expect_val("R4 ones", '0, 1'b1);

    apply("R6 generate cin0", {N{1'b1}}, {N{1'b1}}, 1'b0);
    expect_val("R6 gen 0", {{(N-1){1'b1}}, 1'b0}, 1'b1);
    apply("R6 generate cin1", {N{1'b1}}, {N{1'b1}}, 1'b1);
    expect_val("R6 gen 1", {N{1'b1}}, 1'b1);

    for (int i = 0; i < NB_CARRY; i++)
      apply("R3 block boundary", (32'h1 << (i * K + K - 1)), (32'h1 << (i * K + K - 1)), 1'b0);

    for (int i = 0; i < 300; i++)
      apply("R1 R2 random", $urandom, $urandom, 1'($urandom));

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  localparam int NB_CARRY = N / K;

  initial begin
    #100000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule